// File: doc/BRIEF.md
# Multi-Cycle Load and Branch Sequencer

This block is a small 8-bit processor core that runs a narrow instruction subset: clear the accumulator, load the accumulator, load a 16-bit index register, and take an unconditional relative branch. It drives a synchronous memory bus and issues one read per clock. Memory answers in the same cycle. Each instruction is split into fixed phases: an opcode read, then zero to two operand reads, then zero to two data reads. The exact sequence depends on the addressing mode.

After reset the core reads its start address, most significant byte first, from a fixed two-byte vector. The core keeps a program counter, an instruction register and an effective-address register. Two outputs report every bus cycle: a valid flag and a phase code. The accumulator and the index register are brought out as ports, so an observer can compare the trace and the architectural state against an independent model cycle by cycle.

Top module: `ldseq_core`

## Requirements
- R1: While reset is low, the accumulator, the index register and the illegal flag are all zero. After reset is released, the first two bus cycles read 0xFFFE and then 0xFFFF, both with phase code 0. The next cycle is an opcode read at the address formed from those two bytes, with the byte from 0xFFFE as the high byte.
- R2: Every bus cycle lasts exactly one clock. The phase codes are 0 for vector, 1 for opcode, 2 for operand and 3 for data. `bus_rd` equals `cyc_valid`, and `bus_wr` and `bus_wdata` are always zero.
- R3: Every instruction starts with an opcode read (phase 1) at the program counter. Each operand read (phase 2) uses the next consecutive address.
- R4: Opcode 0x87 uses one bus cycle, sets the accumulator to zero, and the next opcode read follows at the next address.
- R5: Opcode 0x86 uses two cycles and loads the accumulator with the operand byte.
- R6: Opcode 0x96 uses three cycles. Its data read is at address {0x00, operand}, and the byte read there goes to the accumulator.
- R7: Opcode 0xB6 uses four cycles. Two operand bytes arrive high byte first, then one data read at the address they form loads the accumulator.
- R8: Opcode 0xCE uses three cycles and loads the index register from two operand bytes, high byte first.
- R9: Opcode 0xFE uses five cycles. Two address bytes arrive high byte first. Then data reads at EA and at EA+1 (modulo 2^16) load the high byte and the low byte of the index register.
- R10: Opcode 0x20 uses two cycles. The next opcode read is at (opcode address + 2) plus the sign-extended operand byte, so 0xFE repeats the same branch.
- R11: Any other opcode ends bus activity from the following cycle. From then on `cyc_valid` stays low, `illegal_op` stays high and the registers keep their values until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | output | 16 | Bus address of the current cycle |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe, held low |
| bus_wdata | output | 8 | Write data, held zero |
| bus_rdata | input | 8 | Read data, valid in the same cycle |
| cyc_valid | output | 1 | A bus cycle takes place this clock |
| cyc_kind | output | 2 | Phase code of the current cycle |
| acc_a | output | 8 | Accumulator |
| idx_x | output | 16 | Index register |
| illegal_op | output | 1 | An undefined opcode was fetched and the core has stopped |

## Verification
The bench targets the following corner cases and the fault each one would expose:
- **Direct address high byte.** A data read at a direct address must carry a zero high byte. A core that kept a stale high byte in the effective-address register would read the wrong location.
- **Index load at 0xFFFF.** A two-byte index load from 0xFFFF must wrap its second read to 0x0000. A carry or width fault here would send that read elsewhere.
- **Branch offsets.** Branches with positive, zero, negative and self-looping offsets must land at the address after the branch plus the offset. A core that added the offset to the opcode address would miss by one or two bytes.
- **Undefined opcode.** An undefined opcode must stop all traffic. A core that kept fetching would show as extra valid cycles in the trace.

// File: rtl/ldseq_pkg.sv
// Shared types for the load/branch sequencer.
// Assumes an 8-bit data bus and a 16-bit address bus.
package ldseq_pkg;

    typedef enum logic [2:0] {
        ST_VEC_HI, ST_VEC_LO, ST_OPC, ST_OPR1, ST_OPR2, ST_DAT1, ST_DAT2, ST_HALT
    } seq_state_e;

    typedef enum logic [2:0] {
        OP_CLRA, OP_LDA_IMM, OP_LDA_DIR, OP_LDA_EXT,
        OP_LDX_IMM, OP_LDX_EXT, OP_BRA, OP_BAD
    } op_kind_e;

    typedef enum logic [1:0] {
        CYC_VEC = 2'd0, CYC_OPC = 2'd1, CYC_OPR = 2'd2, CYC_DAT = 2'd3
    } cyc_kind_e;

    localparam logic [7:0] OPC_CLRA    = 8'h87;
    localparam logic [7:0] OPC_LDA_IMM = 8'h86;
    localparam logic [7:0] OPC_LDA_DIR = 8'h96;
    localparam logic [7:0] OPC_LDA_EXT = 8'hB6;
    localparam logic [7:0] OPC_LDX_IMM = 8'hCE;
    localparam logic [7:0] OPC_LDX_EXT = 8'hFE;
    localparam logic [7:0] OPC_BRA     = 8'h20;

endpackage

// File: rtl/ldseq_decode.sv
// Opcode classifier.
// Maps an opcode byte to an instruction kind; anything unknown is OP_BAD.
// Purely combinational.
module ldseq_decode
    import ldseq_pkg::*;
(
    input  logic [7:0] opcode,
    output op_kind_e   kind
);

    // classify the opcode byte
    always_comb begin
        case (opcode)
            OPC_CLRA:    kind = OP_CLRA;
            OPC_LDA_IMM: kind = OP_LDA_IMM;
            OPC_LDA_DIR: kind = OP_LDA_DIR;
            OPC_LDA_EXT: kind = OP_LDA_EXT;
            OPC_LDX_IMM: kind = OP_LDX_IMM;
            OPC_LDX_EXT: kind = OP_LDX_EXT;
            OPC_BRA:     kind = OP_BRA;
            default:     kind = OP_BAD;
        endcase
    end

endmodule

// File: rtl/ldseq_fsm.sv
// Phase sequencer.
// Steps through the vector, opcode, operand and data phases. Each state is
// one bus cycle, except HALT, which is entered on an undefined opcode and
// left only by reset.
// Assumes `kind` is decoded from the live read data in ST_OPC and from the
// instruction register in every other state.
module ldseq_fsm
    import ldseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  op_kind_e   kind,
    output seq_state_e state,
    output logic       cyc_valid,
    output logic [1:0] cyc_kind
);

    seq_state_e state_q, state_d;

    // next-phase selection per addressing mode
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_VEC_HI: state_d = ST_VEC_LO;
            ST_VEC_LO: state_d = ST_OPC;
            ST_OPC: begin
                if (kind == OP_BAD)       state_d = ST_HALT;
                else if (kind == OP_CLRA) state_d = ST_OPC;
                else                      state_d = ST_OPR1;
            end
            ST_OPR1: begin
                case (kind)
                    OP_LDA_IMM, OP_BRA: state_d = ST_OPC;
                    OP_LDA_DIR:         state_d = ST_DAT1;
                    default:            state_d = ST_OPR2;
                endcase
            end
            ST_OPR2: state_d = (kind == OP_LDX_IMM) ? ST_OPC : ST_DAT1;
            ST_DAT1: state_d = (kind == OP_LDX_EXT) ? ST_DAT2 : ST_OPC;
            ST_DAT2: state_d = ST_OPC;
            default: state_d = ST_HALT;
        endcase
    end

    // phase register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_VEC_HI;
        else        state_q <= state_d;
    end

    // cycle status derived from the phase
    always_comb begin
        cyc_valid = (state_q != ST_HALT);
        case (state_q)
            ST_VEC_HI, ST_VEC_LO: cyc_kind = CYC_VEC;
            ST_OPR1, ST_OPR2:     cyc_kind = CYC_OPR;
            ST_DAT1, ST_DAT2:     cyc_kind = CYC_DAT;
            default:              cyc_kind = CYC_OPC;
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/ldseq_datapath.sv
// Register file and address path.
// Holds the program counter, instruction register, effective-address
// register, accumulator and index register, and selects the bus address
// for the current phase.
// Assumes the address is twice the data width.
module ldseq_datapath
    import ldseq_pkg::*;
#(
    parameter int          DW       = 8,
    parameter logic [15:0] VEC_ADDR = 16'hFFFE
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  seq_state_e            state,
    input  op_kind_e              kind,
    input  logic [DW-1:0]         rdata,
    output logic [2*DW-1:0]       addr,
    output logic [DW-1:0]         ir,
    output logic [DW-1:0]         acc,
    output logic [2*DW-1:0]       xreg
);

    localparam int             AW  = 2 * DW;
    localparam logic [AW-1:0]  ONE = AW'(1);
    localparam logic [AW-1:0]  VEC = AW'(VEC_ADDR);

    logic [AW-1:0] pc, ear;
    logic [AW-1:0] rel_off;

    assign rel_off = {{DW{rdata[DW-1]}}, rdata};

    // register updates for each phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc   <= '0;
            ear  <= '0;
            ir   <= '0;
            acc  <= '0;
            xreg <= '0;
        end else begin
            case (state)
                ST_VEC_HI: pc[AW-1:DW] <= rdata;
                ST_VEC_LO: pc[DW-1:0]  <= rdata;
                ST_OPC: begin
                    ir <= rdata;
                    pc <= pc + ONE;
                    if (kind == OP_CLRA) acc <= '0;
                end
                ST_OPR1: begin
                    pc <= pc + ONE;
                    case (kind)
                        OP_LDA_IMM: acc            <= rdata;
                        OP_LDA_DIR: ear            <= {{DW{1'b0}}, rdata};
                        OP_LDX_IMM: xreg[AW-1:DW]  <= rdata;
                        OP_BRA:     pc             <= pc + ONE + rel_off;
                        default:    ear[AW-1:DW]   <= rdata;
                    endcase
                end
                ST_OPR2: begin
                    pc <= pc + ONE;
                    if (kind == OP_LDX_IMM) xreg[DW-1:0] <= rdata;
                    else                    ear[DW-1:0]  <= rdata;
                end
                ST_DAT1: begin
                    if (kind == OP_LDX_EXT) xreg[AW-1:DW] <= rdata;
                    else                    acc           <= rdata;
                end
                ST_DAT2: xreg[DW-1:0] <= rdata;
                default: ;
            endcase
        end
    end

    // bus address for the current phase
    always_comb begin
        case (state)
            ST_VEC_HI: addr = VEC;
            ST_VEC_LO: addr = VEC + ONE;
            ST_DAT1:   addr = ear;
            ST_DAT2:   addr = ear + ONE;
            default:   addr = pc;
        endcase
    end

endmodule

// File: rtl/ldseq_core.sv
// Top of the load/branch sequencer.
// Issues one read per clock on a synchronous bus, with memory answering in
// the same cycle. Never writes.
module ldseq_core
    import ldseq_pkg::*;
#(
    parameter int          DW       = 8,
    parameter logic [15:0] VEC_ADDR = 16'hFFFE
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [2*DW-1:0]   bus_addr,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic [DW-1:0]     bus_wdata,
    input  logic [DW-1:0]     bus_rdata,
    output logic              cyc_valid,
    output logic [1:0]        cyc_kind,
    output logic [DW-1:0]     acc_a,
    output logic [2*DW-1:0]   idx_x,
    output logic              illegal_op
);

    seq_state_e    state;
    op_kind_e      kind;
    logic [DW-1:0] ir;
    logic [DW-1:0] dec_src;

    // decode the live byte during the opcode phase, the held opcode otherwise
    assign dec_src = (state == ST_OPC) ? bus_rdata : ir;

    ldseq_decode u_decode (
        .opcode (dec_src),
        .kind   (kind)
    );

    ldseq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .kind      (kind),
        .state     (state),
        .cyc_valid (cyc_valid),
        .cyc_kind  (cyc_kind)
    );

    ldseq_datapath #(.DW(DW), .VEC_ADDR(VEC_ADDR)) u_dp (
        .clk   (clk),
        .rst_n (rst_n),
        .state (state),
        .kind  (kind),
        .rdata (bus_rdata),
        .addr  (bus_addr),
        .ir    (ir),
        .acc   (acc_a),
        .xreg  (idx_x)
    );

    assign bus_rd     = cyc_valid;
    assign bus_wr     = 1'b0;
    assign bus_wdata  = '0;
    assign illegal_op = (state == ST_HALT);

endmodule

// File: rtl/ldseq_checks.sv
// Temporal checks on the sequencer ports. Attached to ldseq_core by bind.
module ldseq_checks #(
    parameter logic [15:0] VEC_ADDR = 16'hFFFE
) (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] bus_addr,
    input logic        bus_rd,
    input logic        bus_wr,
    input logic [7:0]  bus_rdata,
    input logic        cyc_valid,
    input logic [1:0]  cyc_kind,
    input logic [7:0]  acc_a,
    input logic        illegal_op
);

    // R1: the vector high-byte read is followed by the low-byte read
    a_r1_vector_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && cyc_kind == 2'd0 && bus_addr == VEC_ADDR)
        |=> (cyc_kind == 2'd0 && bus_addr == VEC_ADDR + 16'd1));

    // R2: a valid cycle is a read and never a write
    a_r2_read_only: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_valid |-> (bus_rd && !bus_wr));

    // R4: clear gives a zero accumulator and a fetch at the next address
    a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && cyc_kind == 2'd1 && bus_rdata == 8'h87)
        |=> (cyc_kind == 2'd1 && acc_a == 8'h00 && bus_addr == $past(bus_addr) + 16'd1));

    // R5: an immediate load reads its operand at the next address
    a_r5_imm_operand: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && cyc_kind == 2'd1 && bus_rdata == 8'h86)
        |=> (cyc_kind == 2'd2 && bus_addr == $past(bus_addr) + 16'd1));

    // R6: a direct load reads data from page zero
    a_r6_direct_page: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && cyc_kind == 2'd1 && bus_rdata == 8'h96)
        |=> ##1 (cyc_kind == 2'd3 && bus_addr[15:8] == 8'h00));

    // R9: the second data read of an extended index load is at EA+1
    a_r9_second_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && cyc_kind == 2'd1 && bus_rdata == 8'hFE)
        |=> ##3 (cyc_kind == 2'd3 && bus_addr == $past(bus_addr) + 16'd1));

    // R10: the branch target is the next-instruction address plus the offset
    a_r10_branch_target: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && cyc_kind == 2'd1 && bus_rdata == 8'h20)
        |=> ##1 (cyc_kind == 2'd1 &&
                 bus_addr == $past(bus_addr) + 16'd1 +
                             {{8{$past(bus_rdata[7])}}, $past(bus_rdata)}));

    // R11: once stopped, the core stays stopped and silent
    a_r11_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_op |=> (illegal_op && !cyc_valid));

endmodule

bind ldseq_core ldseq_checks #(.VEC_ADDR(VEC_ADDR)) u_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .bus_rdata  (bus_rdata),
    .cyc_valid  (cyc_valid),
    .cyc_kind   (cyc_kind),
    .acc_a      (acc_a),
    .illegal_op (illegal_op)
);

// File: tb/tb_ldseq_core.sv
// Bench for ldseq_core: random and directed programs, compared cycle by
// cycle against an expected trace built by a bench model.
module tb_ldseq_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr;
    logic        bus_rd, bus_wr;
    logic [7:0]  bus_wdata, bus_rdata;
    logic        cyc_valid;
    logic [1:0]  cyc_kind;
    logic [7:0]  acc_a;
    logic [15:0] idx_x;
    logic        illegal_op;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [7:0]  prog [256];
    logic [15:0] vec;

    always #4 clk = ~clk;

    ldseq_core dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cyc_valid(cyc_valid), .cyc_kind(cyc_kind), .acc_a(acc_a),
        .idx_x(idx_x), .illegal_op(illegal_op)
    );

    // memory image: vector, program page 0x40xx, hashed bytes elsewhere
    function automatic logic [7:0] mem(input logic [15:0] a);
        if (a == 16'hFFFE) return vec[15:8];
        if (a == 16'hFFFF) return vec[7:0];
        if (a[15:8] == 8'h40) return prog[a[7:0]];
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    always_comb bus_rdata = mem(bus_addr);

    // expected trace
    bit          qv[$];
    int          qk[$];
    logic [15:0] qa[$];
    bit          qc[$];
    bit          qi[$];
    logic [7:0]  qA[$];
    logic [15:0] qX[$];
    string       qt[$];
    string       qrt[$];
    logic [7:0]  ma;
    logic [15:0] mx;

    task automatic push(bit v, int k, logic [15:0] a, bit c, bit il, string t, string rt);
        qv.push_back(v); qk.push_back(k); qa.push_back(a); qc.push_back(c);
        qi.push_back(il); qA.push_back(ma); qX.push_back(mx);
        qt.push_back(t); qrt.push_back(rt);
    endtask

    // model of the core, executed from the requirements
    task automatic build_expect(int limit);
        logic [15:0] mpc, ea;
        logic [7:0]  op, off;
        string       rtag;
        qv.delete(); qk.delete(); qa.delete(); qc.delete(); qi.delete();
        qA.delete(); qX.delete(); qt.delete(); qrt.delete();
        ma = 8'h00; mx = 16'h0000; rtag = "R1";
        push(1, 0, 16'hFFFE, 0, 0, "R1", "R1");
        push(1, 0, 16'hFFFF, 0, 0, "R1", "R1");
        mpc = {mem(16'hFFFE), mem(16'hFFFF)};
        while (qv.size() < limit) begin
            op = mem(mpc);
            push(1, 1, mpc, 1, 0, "R3", rtag);
            mpc = mpc + 16'd1;
            case (op)
                8'h87: begin ma = 8'h00; rtag = "R4"; end
                8'h86: begin
                    push(1, 2, mpc, 0, 0, "R5", "R5");
                    ma = mem(mpc); mpc = mpc + 16'd1; rtag = "R5";
                end
                8'h96: begin
                    push(1, 2, mpc, 0, 0, "R6", "R6");
                    ea = {8'h00, mem(mpc)}; mpc = mpc + 16'd1;
                    push(1, 3, ea, 0, 0, "R6", "R6");
                    ma = mem(ea); rtag = "R6";
                end
                8'hB6: begin
                    push(1, 2, mpc, 0, 0, "R7", "R7");
                    ea[15:8] = mem(mpc); mpc = mpc + 16'd1;
                    push(1, 2, mpc, 0, 0, "R7", "R7");
                    ea[7:0] = mem(mpc); mpc = mpc + 16'd1;
                    push(1, 3, ea, 0, 0, "R7", "R7");
                    ma = mem(ea); rtag = "R7";
                end
                8'hCE: begin
                    push(1, 2, mpc, 0, 0, "R8", "R8");
                    mx[15:8] = mem(mpc); mpc = mpc + 16'd1;
                    push(1, 2, mpc, 0, 0, "R8", "R8");
                    mx[7:0] = mem(mpc); mpc = mpc + 16'd1; rtag = "R8";
                end
                8'hFE: begin
                    push(1, 2, mpc, 0, 0, "R9", "R9");
                    ea[15:8] = mem(mpc); mpc = mpc + 16'd1;
                    push(1, 2, mpc, 0, 0, "R9", "R9");
                    ea[7:0] = mem(mpc); mpc = mpc + 16'd1;
                    push(1, 3, ea, 0, 0, "R9", "R9");
                    push(1, 3, ea + 16'd1, 0, 0, "R9", "R9");
                    mx = {mem(ea), mem(ea + 16'd1)}; rtag = "R9";
                end
                8'h20: begin
                    push(1, 2, mpc, 0, 0, "R10", "R10");
                    off = mem(mpc);
                    mpc = mpc + 16'd1 + {{8{off[7]}}, off}; rtag = "R10";
                end
                default: begin
                    while (qv.size() < limit) push(0, 0, 16'h0000, 1, 1, "R11", "R11");
                end
            endcase
        end
    endtask

    task automatic check(bit ok, string tag, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // random program starting at start, ending in a self-loop branch
    task automatic gen_random(logic [15:0] start);
        int p;
        for (int i = 0; i < 256; i++) prog[i] = 8'h00;
        p = int'(start[7:0]);
        while (p < 236) begin
            case ($urandom_range(0, 6))
                0: begin prog[p] = 8'h87; p += 1; end
                1: begin prog[p] = 8'h86; prog[p+1] = 8'($urandom); p += 2; end
                2: begin prog[p] = 8'h96; prog[p+1] = 8'($urandom); p += 2; end
                3: begin prog[p] = 8'hB6; prog[p+1] = 8'($urandom); prog[p+2] = 8'($urandom); p += 3; end
                4: begin prog[p] = 8'hCE; prog[p+1] = 8'($urandom); prog[p+2] = 8'($urandom); p += 3; end
                5: begin prog[p] = 8'hFE; prog[p+1] = 8'($urandom); prog[p+2] = 8'($urandom); p += 3; end
                default: begin
                    int k;
                    k = $urandom_range(0, 3);
                    prog[p] = 8'h20; prog[p+1] = 8'(k); p += 2 + k;
                end
            endcase
        end
        prog[p] = 8'h20; prog[p+1] = 8'hFE;
        vec = start;
    endtask

    // directed corner cases: forward, backward, zero branches, wrap, halt
    task automatic gen_directed();
        for (int i = 0; i < 256; i++) prog[i] = 8'h00;
        prog[8'h00] = 8'h20; prog[8'h01] = 8'h10;              // to 0x4012
        prog[8'h12] = 8'h20; prog[8'h13] = 8'hF0;              // back to 0x4004
        prog[8'h04] = 8'h86; prog[8'h05] = 8'h80;
        prog[8'h06] = 8'h87;
        prog[8'h07] = 8'hFE; prog[8'h08] = 8'hFF; prog[8'h09] = 8'hFF; // EA wraps
        prog[8'h0A] = 8'h96; prog[8'h0B] = 8'hFF;
        prog[8'h0C] = 8'h20; prog[8'h0D] = 8'h00;              // zero offset
        prog[8'h0E] = 8'hCE; prog[8'h0F] = 8'hA5; prog[8'h10] = 8'h5A;
        prog[8'h11] = 8'h00;                                   // undefined
        vec = 16'h4000;
    endtask

    task automatic run_phase(int limit);
        build_expect(limit);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(acc_a == 8'h00, "R1", "reset acc", acc_a, 0);
        check(idx_x == 16'h0000, "R1", "reset x", idx_x, 0);
        check(illegal_op == 1'b0, "R1", "reset illegal", illegal_op, 0);
        rst_n = 1'b1;
        for (int i = 0; i < qv.size(); i++) begin
            #1;
            check(cyc_valid == qv[i], qt[i], "cyc_valid", cyc_valid, qv[i]);
            check(illegal_op == qi[i], qt[i], "illegal_op", illegal_op, qi[i]);
            // R2: read strobe tracks the valid flag, no write activity
            check(bus_rd == cyc_valid && !bus_wr && bus_wdata == 8'h00, "R2",
                  "strobes", {bus_rd, bus_wr}, {cyc_valid, 1'b0});
            if (qv[i]) begin
                check(int'(cyc_kind) == qk[i], qt[i], "cyc_kind", cyc_kind, qk[i]);
                check(bus_addr == qa[i], qt[i], "bus_addr", bus_addr, qa[i]);
            end
            if (qc[i]) begin
                check(acc_a == qA[i], qrt[i], "acc_a", acc_a, qA[i]);
                check(idx_x == qX[i], qrt[i], "idx_x", idx_x, qX[i]);
            end
            @(negedge clk);
        end
    endtask

    initial begin
        int seed_sink;
        seed_sink = $urandom(32'd1357);
        gen_random(16'h4000);
        run_phase(700);
        gen_random(16'h400B);
        run_phase(700);
        gen_directed();
        run_phase(80);
        if (!done) begin
            done = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // watchdog
    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule